// File: doc/BRIEF.md
# Load/Store Data Lane Aligner

This block sits between a load/store pipeline and a 32-bit little-endian data memory port. In little-endian order the least significant byte of a value sits at the lowest address. On the store side the pipeline supplies an access size, the two low address bits and the register operand. The block then drives the write data on the byte lanes the access covers and produces the matching byte enables. Both outputs are combinational, so the memory request leaves in the same cycle.

On the load side the pipeline presents the returned memory word with the same size and offset information and a sign-extend select. The block picks the addressed lanes, widens the value to 32 bits and registers the result. The result comes out one cycle after the memory data was valid, together with a valid strobe. A two-state controller produces the strobe. `LD_IDLE` moves to `LD_EMIT` when the load data is valid. `LD_EMIT` stays in `LD_EMIT` when another load arrives back to back and returns to `LD_IDLE` when none does.

Accesses that are not naturally aligned are not split. They raise an alignment trap. Operations the datapath does not support raise an illegal-operation flag. One such operation is a byte load with sign extension; the other is the reserved size code.

Top module: `lsu_lane_align`

## Requirements
- R1: Size code 2'b00 is a byte. A byte store enables only lane `addr` (`st_be_o` = 1 << addr) and drives the operand's low byte on all four lanes.
- R2: Size code 2'b01 is a halfword. An aligned halfword store drives `st_be_o` = 4'b0011 at offset 0 and 4'b1100 at offset 2, and places the operand's low halfword on both halves of the write data.
- R3: Size code 2'b10 is a word. A word store at offset 0 drives `st_be_o` = 4'b1111 and passes the operand through unchanged.
- R4: A halfword with address bit 0 set, or a word with either low address bit set, is misaligned and raises the trap flag. A trapped store drives `st_be_o` = 4'b0000. A trapped load returns zero with `ld_trap_o` high.
- R5: A byte load returns the byte on lane `addr` in bits 7:0, with bits 31:8 zero.
- R6: A halfword load returns the addressed halfword in bits 15:0. Bits 31:16 are zero when `ld_sext_i` is 0, and copies of the halfword's bit 15 when `ld_sext_i` is 1.
- R7: A word load at offset 0 returns the memory word unchanged, with `ld_sext_i` having no effect.
- R8: A byte load with `ld_sext_i` = 1 raises `ld_illegal_o`, returns zero and does not raise `ld_trap_o`.
- R9: Size code 2'b11 is reserved. On a store it raises `st_illegal_o` with `st_be_o` = 4'b0000. On a load it raises `ld_illegal_o` with a zero result.
- R10: When `ld_req_i` is high at a clock edge, `ld_valid_o` is high in the next cycle with that load's result and flags. When `ld_req_i` is low, `ld_valid_o` goes low in the next cycle and the result outputs hold their value.
- R11: During and after reset, with no load presented, `ld_valid_o` is low and the load result is zero.
- R12: With `st_req_i` low, `st_be_o` is 4'b0000 and neither store flag is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| st_req_i | input | 1 | Store access present this cycle |
| st_size_i | input | 2 | Store size code |
| st_addr_i | input | 2 | Store address low bits |
| st_data_i | input | 32 | Store register operand |
| st_wdata_o | output | 32 | Lane-steered write data |
| st_be_o | output | 4 | Write byte enables |
| st_trap_o | output | 1 | Store misaligned trap |
| st_illegal_o | output | 1 | Store reserved size |
| ld_req_i | input | 1 | Load memory data valid this cycle |
| ld_size_i | input | 2 | Load size code |
| ld_addr_i | input | 2 | Load address low bits |
| ld_sext_i | input | 1 | Sign-extend select |
| ld_rdata_i | input | 32 | Memory read word |
| ld_valid_o | output | 1 | Load result valid strobe |
| ld_data_o | output | 32 | Extended load result |
| ld_trap_o | output | 1 | Load misaligned trap |
| ld_illegal_o | output | 1 | Load illegal operation |

## Verification
Several properties are checked on every cycle:

- The enables are all zero whenever a store traps or no store is present.
- A legal byte store enables exactly one lane.
- A faulting load always returns zero.
- The valid strobe follows the load request by one cycle, and the result holds between loads.

Some behaviour only the bench's scenarios can show:

- The exact lane chosen for each offset.
- The replication pattern of the write data.
- The sign or zero fill of each load size.
- The order in which back-to-back results emerge.

A scoreboard compares these against values derived from the requirements.

// File: rtl/lane_pkg.sv
package lane_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_t;

    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_EMIT = 1'b1
    } ld_state_t;
endpackage

// File: rtl/access_check.sv
module access_check
    import lane_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  acc_size_t        size,
    input  logic [OFF_W-1:0] off,
    input  logic             sext,
    input  logic             is_load,
    output logic             misalign,
    output logic             illegal
);
    always_comb begin
        illegal  = (size == SZ_RSVD) || (is_load && sext && (size == SZ_BYTE));
        misalign = 1'b0;
        if (!illegal) begin
            unique case (size)
                SZ_HALF: misalign = off[0];
                SZ_WORD: misalign = |off;
                default: misalign = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/store_steer.sv
module store_steer
    import lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         req,
    input  logic                         fault,
    input  acc_size_t                    size,
    input  logic [$clog2(DATA_W/8)-1:0]  off,
    input  logic [DATA_W-1:0]            data,
    output logic [DATA_W/8-1:0]          be,
    output logic [DATA_W-1:0]            wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [OFF_W-1:0] half_base;
    assign half_base = {off[OFF_W-1:1], 1'b0};

    always_comb begin
        be = '0;
        unique case (size)
            SZ_BYTE: be = LANES'(1) << off;
            SZ_HALF: be = LANES'(2'b11) << half_base;
            SZ_WORD: be = '1;
            default: be = '0;
        endcase
        if (!req || fault) be = '0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size)
                SZ_BYTE: wdata[8*i +: 8] = data[7:0];
                SZ_HALF: wdata[8*i +: 8] = data[8*(i%2) +: 8];
                default: wdata[8*i +: 8] = data[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/load_extract.sv
module load_extract
    import lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  acc_size_t                    size,
    input  logic [$clog2(DATA_W/8)-1:0]  off,
    input  logic                         sext,
    input  logic [DATA_W-1:0]            rdata,
    output logic [DATA_W-1:0]            value
);
    localparam int OFF_W = $clog2(DATA_W / 8);

    logic [DATA_W-1:0] shifted;
    assign shifted = rdata >> {off, 3'b000};

    always_comb begin
        unique case (size)
            SZ_BYTE: value = {{(DATA_W-8){1'b0}}, shifted[7:0]};
            SZ_HALF: value = {{(DATA_W-16){sext & shifted[15]}}, shifted[15:0]};
            SZ_WORD: value = rdata;
            default: value = '0;
        endcase
    end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         st_req_i,
    input  logic [1:0]                   st_size_i,
    input  logic [$clog2(DATA_W/8)-1:0]  st_addr_i,
    input  logic [DATA_W-1:0]            st_data_i,
    output logic [DATA_W-1:0]            st_wdata_o,
    output logic [DATA_W/8-1:0]          st_be_o,
    output logic                         st_trap_o,
    output logic                         st_illegal_o,
    input  logic                         ld_req_i,
    input  logic [1:0]                   ld_size_i,
    input  logic [$clog2(DATA_W/8)-1:0]  ld_addr_i,
    input  logic                         ld_sext_i,
    input  logic [DATA_W-1:0]            ld_rdata_i,
    output logic                         ld_valid_o,
    output logic [DATA_W-1:0]            ld_data_o,
    output logic                         ld_trap_o,
    output logic                         ld_illegal_o
);
    localparam int LANES = DATA_W / 8;

    acc_size_t st_size, ld_size;
    assign st_size = acc_size_t'(st_size_i);
    assign ld_size = acc_size_t'(ld_size_i);

    logic st_mis, st_ill, ld_mis, ld_ill;
    logic [DATA_W-1:0] ld_value;

    access_check #(.OFF_W($clog2(LANES))) u_st_chk (
        .size(st_size), .off(st_addr_i), .sext(1'b0), .is_load(1'b0),
        .misalign(st_mis), .illegal(st_ill)
    );

    access_check #(.OFF_W($clog2(LANES))) u_ld_chk (
        .size(ld_size), .off(ld_addr_i), .sext(ld_sext_i), .is_load(1'b1),
        .misalign(ld_mis), .illegal(ld_ill)
    );

    store_steer #(.DATA_W(DATA_W)) u_steer (
        .req(st_req_i), .fault(st_mis | st_ill), .size(st_size),
        .off(st_addr_i), .data(st_data_i), .be(st_be_o), .wdata(st_wdata_o)
    );

    assign st_trap_o    = st_req_i & st_mis;
    assign st_illegal_o = st_req_i & st_ill;

    load_extract #(.DATA_W(DATA_W)) u_extract (
        .size(ld_size), .off(ld_addr_i), .sext(ld_sext_i),
        .rdata(ld_rdata_i), .value(ld_value)
    );

    ld_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            LD_IDLE: state_nxt = ld_req_i ? LD_EMIT : LD_IDLE;
            LD_EMIT: state_nxt = ld_req_i ? LD_EMIT : LD_IDLE;
            default: state_nxt = LD_IDLE;
        endcase
    end

    assign ld_valid_o = (state == LD_EMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ld_data_o    <= '0;
            ld_trap_o    <= 1'b0;
            ld_illegal_o <= 1'b0;
        end else if (ld_req_i) begin
            ld_data_o    <= (ld_mis | ld_ill) ? '0 : ld_value;
            ld_trap_o    <= ld_mis;
            ld_illegal_o <= ld_ill;
        end
    end

    // R4
    st_trap_no_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_trap_o |-> (st_be_o == '0));

    // R1
    st_byte_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_i && st_size_i == 2'b00) |-> ($countones(st_be_o) == 1));

    // R12
    st_idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_req_i |-> (st_be_o == '0 && !st_trap_o && !st_illegal_o));

    // R10
    ld_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req_i |=> ld_valid_o);

    // R10
    ld_valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req_i |=> (!ld_valid_o && $stable(ld_data_o)));

    // R8
    ld_fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_o && (ld_trap_o || ld_illegal_o)) |-> (ld_data_o == '0));
endmodule

// File: tb/sim_lsu_lane_align.sv
module sim_lsu_lane_align;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        st_req_i = 0;
    logic [1:0]  st_size_i = 0, st_addr_i = 0;
    logic [31:0] st_data_i = 0;
    logic [31:0] st_wdata_o;
    logic [3:0]  st_be_o;
    logic        st_trap_o, st_illegal_o;
    logic        ld_req_i = 0, ld_sext_i = 0;
    logic [1:0]  ld_size_i = 0, ld_addr_i = 0;
    logic [31:0] ld_rdata_i = 0;
    logic        ld_valid_o, ld_trap_o, ld_illegal_o;
    logic [31:0] ld_data_o;

    lsu_lane_align u0 (.*);

    int checks = 0, failures = 0;
    logic [33:0] exp_q[$];
    string tag_q[$];

    task automatic chk(string tag, logic [33:0] act, logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] m_be(logic [1:0] sz, logic [1:0] a);
        case (sz)
            2'b00: return 4'b0001 << a;
            2'b01: return a[0] ? 4'b0000 : (a[1] ? 4'b1100 : 4'b0011);
            2'b10: return (a == 0) ? 4'b1111 : 4'b0000;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic store_op(logic [1:0] sz, logic [1:0] a, logic [31:0] d);
        string tag;
        logic mis;
        mis = (sz == 2'b01 && a[0]) || (sz == 2'b10 && a != 0);
        tag = (sz == 2'b11) ? "R9" : mis ? "R4" : (sz == 0) ? "R1" : (sz == 1) ? "R2" : "R3";
        @(negedge clk);
        st_req_i = 1; st_size_i = sz; st_addr_i = a; st_data_i = d;
        #1;
        chk(tag, {30'd0, st_trap_o, st_illegal_o}, {30'd0, mis, sz == 2'b11});
        chk(tag, {30'd0, st_be_o}, {30'd0, m_be(sz, a)});
        if (sz == 2'b00) chk(tag, {2'b0, st_wdata_o}, {2'b0, {4{d[7:0]}}});
        if (sz == 2'b01) chk(tag, {2'b0, st_wdata_o}, {2'b0, {2{d[15:0]}}});
        if (sz == 2'b10) chk(tag, {2'b0, st_wdata_o}, {2'b0, d});
    endtask

    // caller is positioned at a negedge
    task automatic load_op(logic [1:0] sz, logic [1:0] a, logic sx, logic [31:0] rd);
        logic mis, ill;
        logic [31:0] exp, sh;
        string tag;
        sh  = rd >> (8 * a);
        ill = (sz == 2'b11) || (sz == 2'b00 && sx);
        mis = !ill && ((sz == 2'b01 && a[0]) || (sz == 2'b10 && a != 0));
        case (sz)
            2'b00: exp = {24'd0, sh[7:0]};
            2'b01: exp = {{16{sx & sh[15]}}, sh[15:0]};
            2'b10: exp = rd;
            default: exp = 0;
        endcase
        if (ill || mis) exp = 0;
        tag = (sz == 2'b11) ? "R9" : ill ? "R8" : mis ? "R4" :
              (sz == 0) ? "R5" : (sz == 1) ? "R6" : "R7";
        ld_req_i = 1; ld_size_i = sz; ld_addr_i = a; ld_sext_i = sx; ld_rdata_i = rd;
        exp_q.push_back({mis, ill, exp});
        tag_q.push_back({tag, "/R10"});
        @(negedge clk);
    endtask

    task automatic ld_idle();
        ld_req_i = 0; ld_rdata_i = 32'hFFFF_FFFF;
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && ld_valid_o) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 actual=unexpected_valid expected=no_valid");
            end else begin
                logic [33:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {ld_trap_o, ld_illegal_o, ld_data_o}, e);
            end
        end
    end

    bit done = 0;
    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", {1'b0, ld_valid_o, ld_data_o}, 34'd0);
        rst_n = 1;
        @(negedge clk);
        chk("R11", {1'b0, ld_valid_o, ld_data_o}, 34'd0);
        // R12 idle store
        chk("R12", {28'd0, st_be_o, st_trap_o, st_illegal_o}, 34'd0);

        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 4; a++) begin
                store_op(2'(s), 2'(a), 32'hDEAD_BE8F);
                store_op(2'(s), 2'(a), 32'h1357_2468);
            end
        @(negedge clk);
        st_req_i = 0; st_size_i = 2'b10; st_addr_i = 0;
        #1;
        chk("R12", {28'd0, st_be_o, st_trap_o, st_illegal_o}, 34'd0);

        @(negedge clk);
        // back-to-back loads over all sizes, offsets and extend selects
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 4; a++)
                for (int x = 0; x < 2; x++) begin
                    load_op(2'(s), 2'(a), x[0], 32'h8C7B_F6A5);
                    load_op(2'(s), 2'(a), x[0], 32'h1234_5678);
                end
        ld_idle();
        // R10 strobe drops and result holds without a load
        begin
            logic [31:0] held;
            held = ld_data_o;
            ld_idle();
            chk("R10", {1'b0, ld_valid_o, ld_data_o}, {1'b0, 1'b0, held});
        end
        // isolated loads with idle gaps
        load_op(2'b01, 2'b10, 1'b1, 32'h8001_7FFF);
        ld_idle();
        load_op(2'b01, 2'b00, 1'b1, 32'h8001_7FFF);
        ld_idle();
        load_op(2'b00, 2'b11, 1'b0, 32'hA5B6_C7D8);
        ld_idle();
        ld_idle();
        chk("R10", {33'd0, ld_valid_o}, 34'd0);
        chk("R10", {2'b0, 32'(exp_q.size())}, 34'd0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule